// File: doc/BRIEF.md
# Horizontal microprogrammed control unit

This block is the control section of a small processor. Every microinstruction is wide and horizontal, and each one sets several independent parts of the machine in the same clock tick. The control store is a constant table that is computed inside the design. On each tick one microword is read from it. That word names:

- two ALU operand sources,
- one destination register,
- an ALU function,
- a sequencing action,
- a jump target.

The datapath holds a program counter, a memory address register, a memory data register, an instruction register, two general registers and an ALU.

A simple memory model is included. After the memory address register is written, the memory data register captures the external read data a fixed number of ticks later. A dispatch step uses the opcode in the instruction register to choose the next microroutine. A short microprogram implements a small instruction set: no-op, absolute jump, load immediate, register add, subtract, XOR and move, an indexed load that re-aims the memory address, and halt.

Top module: `hmc_core`

## Requirements
- R1: A synchronous reset sets the micro-address to 0 (the fetch entry). It also clears PC, MAR, MDR, IR, R0 and R1 to zero.
- R2: The microword has six fields, from MSB to LSB:
  - source A (bits 18:16), encoded 0 none, 1 PC, 2 MAR, 3 MDR, 4 IR, 5 R0, 6 R1, 7 constant one;
  - source B (bits 15:13), with the same encoding;
  - destination (bits 12:10), with the same encoding;
  - ALU function (bits 9:7), encoded 0 copy A, 1 A+B, 2 A-B, 3 AND, 4 OR, 5 XOR;
  - sequencing (bits 6:5);
  - jump address (bits 4:0).

  Exactly one word is fetched and acted on per tick.
- R3: Sequencing code 0 (next) makes the next micro-address the current one plus 1.
- R4: Sequencing code 1 (jump) loads the next micro-address from the jump-address field. Code 3 (hold) keeps the current micro-address.
- R5: Sequencing code 2 (dispatch) takes the next micro-address from IR[15:12] as follows. Every other opcode goes to 0.

  | Opcode | Micro-address |
  |---|---|
  | 1 | 7 |
  | 2 | 9 |
  | 3 | 11 |
  | 4 | 12 |
  | 5 | 13 |
  | 6 | 14 |
  | 7 | 16 |
  | 15 | 15 |

- R6: A destination of none (or constant one) writes no register. The other fields of the same word still act.
- R7: A register write takes effect at the end of the tick. Sources read in that tick see the old values.
- R8: MDR captures mem_rdata_i, which is driven for address MAR[7:0], exactly two ticks after MAR is written. Writing MAR again restarts the two-tick count.
- R9: The jump instruction (opcode 1, target in the next word) takes two microword ticks. In the first tick MAR receives MDR. In the second, PC receives MAR+1 and the micro-address becomes 2, the decode entry.
- R10: An instruction is fetched from address PC, and PC is then incremented. The instructions behave as follows:

  | Opcode | Effect |
  |---|---|
  | 0 | no-op |
  | 2 | R0 = next word |
  | 3 | R0 = R0+R1 |
  | 4 | R1 = R0 |
  | 5 | R0 = R0^R1 |
  | 6 | R0 = R0-R1 |
  | 7 | R0 = mem[next word + 1] |
  | unknown | no-op |

- R11: Opcode 15 halts. The micro-address then stays at 15 and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata_i | input | DW | Memory read data for address mem_addr_o |
| mem_addr_o | output | MAW | Memory address, low bits of MAR |
| upc_o | output | 5 | Current micro-address |
| pc_o | output | DW | Program counter |
| mar_o | output | DW | Memory address register |
| mdr_o | output | DW | Memory data register |
| ir_o | output | DW | Instruction register |
| r0_o | output | DW | General register 0 |
| r1_o | output | DW | General register 1 |

## Verification
The assertions check the following on every tick:
- the micro-address step for next, jump and hold;
- the stability of registers under a none destination and of MAR whenever it is not the destination;
- the two-tick arrival of memory data in MDR;
- both steps of the jump routine.

Only the bench's program runs can show the following:
- the dispatch targets;
- the results of whole instructions;
- the restart of the memory count when MAR is rewritten back to back;
- the reset values;
- that a halted machine stays put.

// File: rtl/hmc_pkg.sv
package hmc_pkg;

    localparam int UA_W     = 5;
    localparam int CS_DEPTH = 1 << UA_W;
    localparam int OPC_W    = 4;

    typedef enum logic [2:0] {
        RS_NONE = 3'd0, RS_PC = 3'd1, RS_MAR = 3'd2, RS_MDR = 3'd3,
        RS_IR   = 3'd4, RS_R0 = 3'd5, RS_R1  = 3'd6, RS_ONE = 3'd7
    } reg_sel_e;

    typedef enum logic [2:0] {
        ALU_COPY = 3'd0, ALU_ADD = 3'd1, ALU_SUB = 3'd2, ALU_AND = 3'd3,
        ALU_OR   = 3'd4, ALU_XOR = 3'd5, ALU_RS6 = 3'd6, ALU_RS7 = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SQ_NEXT = 2'd0, SQ_JMP = 2'd1, SQ_DISPATCH = 2'd2, SQ_HOLD = 2'd3
    } seq_e;

    // Field order is fixed: source A, source B, destination, ALU, sequencing, jump address
    typedef struct packed {
        reg_sel_e         src_a;
        reg_sel_e         src_b;
        reg_sel_e         dst;
        alu_op_e          alu;
        seq_e             seq;
        logic [UA_W-1:0]  jaddr;
    } uword_t;

    localparam logic [UA_W-1:0] UA_FETCH    = UA_W'(0);
    localparam logic [UA_W-1:0] UA_DECODE   = UA_W'(2);
    localparam logic [UA_W-1:0] UA_JUMP0    = UA_W'(7);
    localparam logic [UA_W-1:0] UA_JUMP1    = UA_W'(8);
    localparam logic [UA_W-1:0] UA_LDI      = UA_W'(9);
    localparam logic [UA_W-1:0] UA_ADD      = UA_W'(11);
    localparam logic [UA_W-1:0] UA_MOV      = UA_W'(12);
    localparam logic [UA_W-1:0] UA_XOR      = UA_W'(13);
    localparam logic [UA_W-1:0] UA_SUB      = UA_W'(14);
    localparam logic [UA_W-1:0] UA_HALT     = UA_W'(15);
    localparam logic [UA_W-1:0] UA_LDX      = UA_W'(16);

    function automatic uword_t mk(reg_sel_e a, reg_sel_e b, reg_sel_e d,
                                  alu_op_e op, seq_e s, logic [UA_W-1:0] j);
        uword_t w;
        w.src_a = a;
        w.src_b = b;
        w.dst   = d;
        w.alu   = op;
        w.seq   = s;
        w.jaddr = j;
        return w;
    endfunction

    // Microprogram contents, indexed by micro-address
    function automatic uword_t ucode(logic [UA_W-1:0] a);
        case (a)
            UA_W'(0):  return mk(RS_PC,   RS_NONE, RS_MAR,  ALU_COPY, SQ_NEXT,     '0);
            UA_W'(1):  return mk(RS_PC,   RS_ONE,  RS_PC,   ALU_ADD,  SQ_NEXT,     '0);
            UA_W'(2):  return mk(RS_NONE, RS_NONE, RS_NONE, ALU_COPY, SQ_NEXT,     '0);
            UA_W'(3):  return mk(RS_MDR,  RS_NONE, RS_IR,   ALU_COPY, SQ_NEXT,     '0);
            UA_W'(4):  return mk(RS_PC,   RS_NONE, RS_MAR,  ALU_COPY, SQ_NEXT,     '0);
            UA_W'(5):  return mk(RS_NONE, RS_NONE, RS_NONE, ALU_COPY, SQ_NEXT,     '0);
            UA_W'(6):  return mk(RS_NONE, RS_NONE, RS_NONE, ALU_COPY, SQ_DISPATCH, '0);
            UA_W'(7):  return mk(RS_MDR,  RS_NONE, RS_MAR,  ALU_COPY, SQ_NEXT,     '0);
            UA_W'(8):  return mk(RS_MAR,  RS_ONE,  RS_PC,   ALU_ADD,  SQ_JMP,      UA_DECODE);
            UA_W'(9):  return mk(RS_MDR,  RS_NONE, RS_R0,   ALU_COPY, SQ_NEXT,     '0);
            UA_W'(10): return mk(RS_PC,   RS_ONE,  RS_PC,   ALU_ADD,  SQ_JMP,      UA_FETCH);
            UA_W'(11): return mk(RS_R0,   RS_R1,   RS_R0,   ALU_ADD,  SQ_JMP,      UA_FETCH);
            UA_W'(12): return mk(RS_R0,   RS_NONE, RS_R1,   ALU_COPY, SQ_JMP,      UA_FETCH);
            UA_W'(13): return mk(RS_R0,   RS_R1,   RS_R0,   ALU_XOR,  SQ_JMP,      UA_FETCH);
            UA_W'(14): return mk(RS_R0,   RS_R1,   RS_R0,   ALU_SUB,  SQ_JMP,      UA_FETCH);
            UA_W'(15): return mk(RS_NONE, RS_NONE, RS_NONE, ALU_COPY, SQ_HOLD,     '0);
            UA_W'(16): return mk(RS_MDR,  RS_NONE, RS_MAR,  ALU_COPY, SQ_NEXT,     '0);
            UA_W'(17): return mk(RS_MAR,  RS_ONE,  RS_MAR,  ALU_ADD,  SQ_NEXT,     '0);
            UA_W'(18): return mk(RS_NONE, RS_NONE, RS_NONE, ALU_COPY, SQ_NEXT,     '0);
            UA_W'(19): return mk(RS_NONE, RS_NONE, RS_NONE, ALU_COPY, SQ_NEXT,     '0);
            UA_W'(20): return mk(RS_MDR,  RS_NONE, RS_R0,   ALU_COPY, SQ_NEXT,     '0);
            UA_W'(21): return mk(RS_PC,   RS_ONE,  RS_PC,   ALU_ADD,  SQ_JMP,      UA_FETCH);
            default:   return mk(RS_NONE, RS_NONE, RS_NONE, ALU_COPY, SQ_NEXT,     '0);
        endcase
    endfunction

    // Opcode to microroutine entry
    function automatic logic [UA_W-1:0] dispatch_target(logic [OPC_W-1:0] opc);
        case (opc)
            OPC_W'(1):  return UA_JUMP0;
            OPC_W'(2):  return UA_LDI;
            OPC_W'(3):  return UA_ADD;
            OPC_W'(4):  return UA_MOV;
            OPC_W'(5):  return UA_XOR;
            OPC_W'(6):  return UA_SUB;
            OPC_W'(7):  return UA_LDX;
            OPC_W'(15): return UA_HALT;
            default:    return UA_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/hmc_ctrl_store.sv
module hmc_ctrl_store
    import hmc_pkg::*;
(
    input  logic [UA_W-1:0] uaddr_i,
    output uword_t          uword_o
);

    uword_t rom [CS_DEPTH];

    for (genvar gi = 0; gi < CS_DEPTH; gi++) begin : g_rom
        assign rom[gi] = ucode(UA_W'(gi));
    end

    assign uword_o = rom[uaddr_i];

endmodule

// File: rtl/hmc_useq.sv
module hmc_useq
    import hmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_e             seq_i,
    input  logic [UA_W-1:0]  jaddr_i,
    input  logic [OPC_W-1:0] opcode_i,
    output logic [UA_W-1:0]  upc_o
);

    typedef struct packed {
        logic [UA_W-1:0] upc;
    } sq_state_t;

    sq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (seq_i)
            SQ_NEXT:     state_d.upc = state_q.upc + UA_W'(1);
            SQ_JMP:      state_d.upc = jaddr_i;
            SQ_DISPATCH: state_d.upc = dispatch_target(opcode_i);
            default:     state_d.upc = state_q.upc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.upc <= UA_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    assign upc_o = state_q.upc;

endmodule

// File: rtl/hmc_alu.sv
module hmc_alu
    import hmc_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e         op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic [DW-1:0]   res_o
);

    always_comb begin
        case (op_i)
            ALU_ADD: res_o = a_i + b_i;
            ALU_SUB: res_o = a_i - b_i;
            ALU_AND: res_o = a_i & b_i;
            ALU_OR:  res_o = a_i | b_i;
            ALU_XOR: res_o = a_i ^ b_i;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/hmc_dpath.sv
module hmc_dpath
    import hmc_pkg::*;
#(
    parameter int DW      = 16,
    parameter int MAW     = 8,
    parameter int MEM_LAT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  uword_t          uw_i,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [MAW-1:0]  mem_addr_o,
    output logic [DW-1:0]   pc_o,
    output logic [DW-1:0]   mar_o,
    output logic [DW-1:0]   mdr_o,
    output logic [DW-1:0]   ir_o,
    output logic [DW-1:0]   r0_o,
    output logic [DW-1:0]   r1_o
);

    localparam int CW = $clog2(MEM_LAT + 1);

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] mar;
        logic [DW-1:0] mdr;
        logic [DW-1:0] ir;
        logic [DW-1:0] r0;
        logic [DW-1:0] r1;
        logic [CW-1:0] cnt;
    } dp_state_t;

    dp_state_t     state_d, state_q;
    logic [DW-1:0] opa, opb, alu_res;

    function automatic logic [DW-1:0] pick(reg_sel_e s, dp_state_t st);
        case (s)
            RS_PC:   return st.pc;
            RS_MAR:  return st.mar;
            RS_MDR:  return st.mdr;
            RS_IR:   return st.ir;
            RS_R0:   return st.r0;
            RS_R1:   return st.r1;
            RS_ONE:  return DW'(1);
            default: return '0;
        endcase
    endfunction

    always_comb begin
        opa = pick(uw_i.src_a, state_q);
        opb = pick(uw_i.src_b, state_q);
    end

    hmc_alu #(.DW(DW)) alu_i (
        .op_i  (uw_i.alu),
        .a_i   (opa),
        .b_i   (opb),
        .res_o (alu_res)
    );

    always_comb begin
        state_d = state_q;
        // memory return countdown
        if (state_q.cnt != '0) begin
            state_d.cnt = state_q.cnt - CW'(1);
            if (state_q.cnt == CW'(1)) begin
                state_d.mdr = mem_rdata_i;
            end
        end
        // microword destination write; a direct MDR write wins over a return
        case (uw_i.dst)
            RS_PC:   state_d.pc = alu_res;
            RS_MAR: begin
                state_d.mar = alu_res;
                state_d.cnt = CW'(MEM_LAT);
            end
            RS_MDR:  state_d.mdr = alu_res;
            RS_IR:   state_d.ir  = alu_res;
            RS_R0:   state_d.r0  = alu_res;
            RS_R1:   state_d.r1  = alu_res;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_addr_o = state_q.mar[MAW-1:0];
    assign pc_o       = state_q.pc;
    assign mar_o      = state_q.mar;
    assign mdr_o      = state_q.mdr;
    assign ir_o       = state_q.ir;
    assign r0_o       = state_q.r0;
    assign r1_o       = state_q.r1;

endmodule

// File: rtl/hmc_core.sv
module hmc_core
    import hmc_pkg::*;
#(
    parameter int DW      = 16,
    parameter int MAW     = 8,
    parameter int MEM_LAT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [MAW-1:0]  mem_addr_o,
    output logic [UA_W-1:0] upc_o,
    output logic [DW-1:0]   pc_o,
    output logic [DW-1:0]   mar_o,
    output logic [DW-1:0]   mdr_o,
    output logic [DW-1:0]   ir_o,
    output logic [DW-1:0]   r0_o,
    output logic [DW-1:0]   r1_o
);

    uword_t          uw;
    logic [UA_W-1:0] upc;

    hmc_ctrl_store cs_i (
        .uaddr_i (upc),
        .uword_o (uw)
    );

    hmc_useq seq_i (
        .clk      (clk),
        .rst      (rst),
        .seq_i    (uw.seq),
        .jaddr_i  (uw.jaddr),
        .opcode_i (ir_o[DW-1 -: OPC_W]),
        .upc_o    (upc)
    );

    hmc_dpath #(.DW(DW), .MAW(MAW), .MEM_LAT(MEM_LAT)) dp_i (
        .clk         (clk),
        .rst         (rst),
        .uw_i        (uw),
        .mem_rdata_i (mem_rdata_i),
        .mem_addr_o  (mem_addr_o),
        .pc_o        (pc_o),
        .mar_o       (mar_o),
        .mdr_o       (mdr_o),
        .ir_o        (ir_o),
        .r0_o        (r0_o),
        .r1_o        (r1_o)
    );

    assign upc_o = upc;

endmodule

// File: rtl/hmc_core_chk.sv
module hmc_core_chk
    import hmc_pkg::*;
#(
    parameter int DW      = 16,
    parameter int MEM_LAT = 2
) (
    input logic            clk,
    input logic            rst,
    input uword_t          uw,
    input logic [UA_W-1:0] upc_o,
    input logic [DW-1:0]   pc_o,
    input logic [DW-1:0]   mar_o,
    input logic [DW-1:0]   mdr_o,
    input logic [DW-1:0]   ir_o,
    input logic [DW-1:0]   r0_o,
    input logic [DW-1:0]   r1_o,
    input logic [DW-1:0]   mem_rdata_i
);

    AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (rst)
        uw.seq == SQ_NEXT |=> upc_o == UA_W'($past(upc_o) + UA_W'(1))); // R3

    AST_SEQ_JMP: assert property (@(posedge clk) disable iff (rst)
        uw.seq == SQ_JMP |=> upc_o == $past(uw.jaddr)); // R4

    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        uw.seq == SQ_HOLD |=> $stable(upc_o) && $stable(pc_o) && $stable(r0_o) && $stable(r1_o)); // R11

    AST_NONE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (uw.dst == RS_NONE || uw.dst == RS_ONE)
        |=> $stable(pc_o) && $stable(ir_o) && $stable(r0_o) && $stable(r1_o)); // R6

    AST_MAR_ONLY_BY_DST: assert property (@(posedge clk) disable iff (rst)
        uw.dst != RS_MAR |=> $stable(mar_o)); // R6

    AST_JUMP_FIRST: assert property (@(posedge clk) disable iff (rst)
        upc_o == UA_JUMP0 |=> upc_o == UA_JUMP1 && mar_o == $past(mdr_o)); // R9

    AST_JUMP_SECOND: assert property (@(posedge clk) disable iff (rst)
        upc_o == UA_JUMP1 |=> upc_o == UA_DECODE && pc_o == DW'($past(mar_o) + DW'(1))); // R9

    if (MEM_LAT == 2) begin : g_lat2
        AST_MDR_RETURN: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) && $past(uw.dst, 2) == RS_MAR
             && $past(uw.dst) != RS_MAR && uw.dst != RS_MAR && uw.dst != RS_MDR)
            |=> mdr_o == $past(mem_rdata_i)); // R8
    end

endmodule

bind hmc_core hmc_core_chk #(.DW(DW), .MEM_LAT(MEM_LAT)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .uw          (uw),
    .upc_o       (upc_o),
    .pc_o        (pc_o),
    .mar_o       (mar_o),
    .mdr_o       (mdr_o),
    .ir_o        (ir_o),
    .r0_o        (r0_o),
    .r1_o        (r1_o),
    .mem_rdata_i (mem_rdata_i)
);

// File: tb/hmc_core_tb_top.sv
module hmc_core_tb_top;

    localparam int DW  = 16;
    localparam int MAW = 8;
    localparam int UAW = hmc_pkg::UA_W;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [DW-1:0]  mem_rdata;
    logic [MAW-1:0] mem_addr;
    logic [UAW-1:0] upc_o;
    logic [DW-1:0]  pc_o, mar_o, mdr_o, ir_o, r0_o, r1_o;
    logic [DW-1:0]  mem [256];

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit timeout = 1'b0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    hmc_core dut_i (
        .clk(clk), .rst(rst), .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr),
        .upc_o(upc_o), .pc_o(pc_o), .mar_o(mar_o), .mdr_o(mdr_o),
        .ir_o(ir_o), .r0_o(r0_o), .r1_o(r1_o)
    );

    // ---------------- reference model (behavioural, per tick) ----------------
    int            rupc, rcnt;
    logic [DW-1:0] rpc, rmar, rmdr, rir, rr0, rr1;

    function automatic int disp(logic [3:0] opc);
        case (opc)
            4'd1: return 7;   4'd2: return 9;   4'd3: return 11;
            4'd4: return 12;  4'd5: return 13;  4'd6: return 14;
            4'd7: return 16;  4'd15: return 15;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int            nupc, ncnt;
        logic [DW-1:0] npc, nmar, nmdr, nir, nr0, nr1;
        if (rst) begin
            rupc = 0; rcnt = 0;
            rpc = '0; rmar = '0; rmdr = '0; rir = '0; rr0 = '0; rr1 = '0;
        end else begin
            npc = rpc; nmar = rmar; nmdr = rmdr; nir = rir; nr0 = rr0; nr1 = rr1;
            ncnt = (rcnt > 0) ? rcnt - 1 : 0;
            if (rcnt == 1) nmdr = mem[rmar[MAW-1:0]];
            nupc = rupc + 1;
            case (rupc)
                0:  begin nmar = rpc; ncnt = 2; end
                1:  npc = rpc + 16'd1;
                3:  nir = rmdr;
                4:  begin nmar = rpc; ncnt = 2; end
                6:  nupc = disp(rir[15:12]);
                7:  begin nmar = rmdr; ncnt = 2; end
                8:  begin npc = rmar + 16'd1; nupc = 2; end
                9:  nr0 = rmdr;
                10: begin npc = rpc + 16'd1; nupc = 0; end
                11: begin nr0 = rr0 + rr1; nupc = 0; end
                12: begin nr1 = rr0; nupc = 0; end
                13: begin nr0 = rr0 ^ rr1; nupc = 0; end
                14: begin nr0 = rr0 - rr1; nupc = 0; end
                15: nupc = 15;
                16: begin nmar = rmdr; ncnt = 2; end
                17: begin nmar = rmar + 16'd1; ncnt = 2; end
                20: nr0 = rmdr;
                21: begin npc = rpc + 16'd1; nupc = 0; end
                default: ;
            endcase
            rupc = nupc % 32; rcnt = ncnt;
            rpc = npc; rmar = nmar; rmdr = nmdr; rir = nir; rr0 = nr0; rr1 = nr1;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 R4 R5", "upc", 32'(upc_o), 32'(rupc));
        chk("R6 R7 R10",   "pc",  32'(pc_o),  32'(rpc));
        chk("R6 R8",       "mar", 32'(mar_o), 32'(rmar));
        chk("R8",          "mdr", 32'(mdr_o), 32'(rmdr));
        chk("R10",         "ir",  32'(ir_o),  32'(rir));
        chk("R7 R10",      "r0",  32'(r0_o),  32'(rr0));
        chk("R7 R10",      "r1",  32'(r1_o),  32'(rr1));
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            if (cyc > 50000) timeout = 1'b1;
            compare_all();
        end
    endtask

    task automatic check_reset_state();
        chk("R1", "reset upc", 32'(upc_o), 32'd0);
        chk("R1", "reset pc",  32'(pc_o),  32'd0);
        chk("R1", "reset mar", 32'(mar_o), 32'd0);
        chk("R1", "reset mdr", 32'(mdr_o), 32'd0);
        chk("R1", "reset ir",  32'(ir_o),  32'd0);
        chk("R1", "reset r0",  32'(r0_o),  32'd0);
        chk("R1", "reset r1",  32'(r1_o),  32'd0);
    endtask

    task automatic run_to_halt();
        int n = 0;
        while (!(rupc == 15 && upc_o == 5'd15) && n < 3000 && !timeout) begin
            step(1);
            n++;
        end
        step(20);
        chk("R11 R4", "halt holds upc", 32'(upc_o), 32'd15);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    initial begin
        clear_mem();
        // Program A: LDI, MOV, LDI, ADD, JUMP, SUB, XOR, LDX (restart), NOP, unknown, HALT
        mem[8'h00] = 16'h2000; mem[8'h01] = 16'h0005;
        mem[8'h02] = 16'h4000;
        mem[8'h03] = 16'h2000; mem[8'h04] = 16'h0003;
        mem[8'h05] = 16'h3000;
        mem[8'h06] = 16'h1000; mem[8'h07] = 16'h0020;
        mem[8'h08] = 16'hF000;
        mem[8'h20] = 16'h6000;
        mem[8'h21] = 16'h5000;
        mem[8'h22] = 16'h7000; mem[8'h23] = 16'h0040;
        mem[8'h24] = 16'h0000;
        mem[8'h25] = 16'h9000;
        mem[8'h26] = 16'hF000;
        mem[8'h40] = 16'h1111; mem[8'h41] = 16'hBEEF;

        rst = 1'b1;
        @(posedge clk);
        step(2);
        check_reset_state();
        rst = 1'b0;
        run_to_halt();
        chk("R8 R10", "prog A r0 (indexed load after MAR restart)", 32'(r0_o), 32'h0000BEEF);
        chk("R10",    "prog A r1", 32'(r1_o), 32'h00000005);
        chk("R9 R10", "prog A pc after jump and halt", 32'(pc_o), 32'h00000027);
        chk("R5 R11", "prog A ir holds halt", 32'(ir_o), 32'h0000F000);

        // Program B: reset mid-state, jump first, load, move, add with wrap, halt
        rst = 1'b1;
        clear_mem();
        mem[8'h00] = 16'h1000; mem[8'h01] = 16'h0010;
        mem[8'h10] = 16'h2000; mem[8'h11] = 16'hFFFF;
        mem[8'h12] = 16'h4000;
        mem[8'h13] = 16'h3000;
        mem[8'h14] = 16'hF000;
        step(2);
        check_reset_state();
        rst = 1'b0;
        begin
            int n = 0;
            while (upc_o != 5'd8 && n < 200 && !timeout) begin
                step(1);
                n++;
            end
        end
        chk("R9", "second jump tick upc", 32'(upc_o), 32'd8);
        chk("R9", "mar holds target", 32'(mar_o), 32'h00000010);
        step(1);
        chk("R9", "pc = target+1 after jump", 32'(pc_o), 32'h00000011);
        chk("R9", "upc at decode entry", 32'(upc_o), 32'd2);
        run_to_halt();
        chk("R10", "prog B r0 wraps", 32'(r0_o), 32'h0000FFFE);
        chk("R10", "prog B r1", 32'(r1_o), 32'h0000FFFF);
        chk("R10", "prog B pc", 32'(pc_o), 32'h00000015);

        if (timeout) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule